// File: doc/BRIEF.md
# USB Interrupt Status Aggregator

This block holds the 8-bit interrupt status word of a small USB device controller. It folds the interrupt source vector of each of four endpoints into one summary flag per endpoint. It also watches the decoded bus line state and raises a suspend flag after a long idle period. A resume flag is raised on activity leaving the idle state, or when the internal clock is reported stopped. The CPU reads the word and may write it. A single interrupt request line goes high while any defined flag is set.

The endpoint flags are read-only views of the per-endpoint source vectors. The suspend flag is cleared by software writing a 0 to it. The resume flag has no write path at all: it clears only while its enable input is low. Everything runs on the 48 MHz USB clock. The bus state input is assumed already synchronised to that clock.

Top module: `usb_irq_status`

## Requirements
- R1: After reset every bit of `rd_data` is 0 and `irq` is 0.
- R2: Bit i of `rd_data` (i = 0..3) equals the OR of source byte `ep_src[8*i+7:8*i]` sampled at the previous clock edge. It stays 1 while any bit of that byte is 1 and returns to 0 only when the whole byte is 0.
- R3: CPU writes (`wr_en` = 1) do not change bits 3:0 or bit 7, whatever the value of `wr_data`.
- R4: Bits 5:4 of `rd_data` always read 0, including after writes of 1 to them.
- R5: `bus_state` encoding is 00 = SE0, 01 = J, 10 = K, 11 = invalid. Any value other than J counts as not idle. The suspend flag (bit 6) becomes 1 at the clock edge that samples J for the IDLE_CYCLES-th consecutive time. Any non-J sample restarts the count. Within one unbroken J period the flag is set only once.
- R6: A write with `wr_data[6]` = 0 clears the suspend flag at that edge. A write with `wr_data[6]` = 1 never sets it. If the timer sets the flag at the same edge as a clearing write, the set wins.
- R7: While `resume_en` = 1, the resume flag (bit 7) is set at an edge where the previous sample of `bus_state` was J and the current one is K or SE0. A change to 11 does not set it. It is also set at any edge where `clk_stopped` = 1.
- R8: At any edge where `resume_en` = 0, the resume flag becomes 0. It stays 0 while `resume_en` stays 0.
- R9: `irq` is the OR of bits 3:0, 6 and 7 of `rd_data` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz USB clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_src | input | NUM_EP*SRC_W | Per-endpoint interrupt source vectors; byte i belongs to endpoint i |
| bus_state | input | 2 | Decoded, synchronised bus line state |
| resume_en | input | 1 | Resume detection enable; low clears the resume flag |
| clk_stopped | input | 1 | High while the internal clock is stopped |
| wr_en | input | 1 | CPU write strobe for the status word |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Current status word |
| irq | output | 1 | Interrupt request, OR of all defined flags |

## Verification
The endpoint summaries are tried with three kinds of source pattern. A single set bit and several endpoints set at once show whether the byte-to-flag mapping is right. A byte that changes from one nonzero value to another shows whether a flag clears before its byte is fully zero. The idle timer is run with an unbroken J period, with a J period cut short by K and by SE0, and with a software clear in the middle of a continuing J period. These tell apart a wrong threshold, a counter that does not restart, and a flag that sets again. The resume logic is driven with J leaving to K, to SE0 and to the invalid code, with the enable low, and with the clock-stopped input. These separate the edge rule from the enable gating.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    typedef enum logic [1:0] {
        LINE_SE0 = 2'b00,
        LINE_J   = 2'b01,
        LINE_K   = 2'b10,
        LINE_BAD = 2'b11
    } line_t;

    localparam int STAT_W   = 8;
    localparam int SUSP_POS = 6;
    localparam int RESM_POS = 7;

endpackage

// File: rtl/ep_summary.sv
module ep_summary #(
    parameter int NUM_EP = 4,
    parameter int SRC_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_EP*SRC_W-1:0]   src,
    output logic [NUM_EP-1:0]         flags
);

    typedef struct packed {
        logic [NUM_EP-1:0] any;
    } sum_state_t;

    sum_state_t st_d, st_q;
    logic [NUM_EP-1:0] any_now;

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        assign any_now[e] = |src[e*SRC_W +: SRC_W];
    end

    always_comb begin
        st_d     = st_q;
        st_d.any = any_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.any;

endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
    parameter int IDLE_CYCLES = 144000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic is_idle,
    output logic expire
);

    localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_CYCLES);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(IDLE_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!is_idle)
            st_d.cnt = '0;
        else if (st_q.cnt != LIMIT)
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expire = is_idle && (st_q.cnt == LAST);

endmodule

// File: rtl/line_edge.sv
module line_edge
    import usb_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  line_t line,
    output logic  j_exit
);

    typedef struct packed {
        line_t prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: LINE_SE0};
        else        st_q <= st_d;
    end

    assign j_exit = (st_q.prev == LINE_J) && ((line == LINE_K) || (line == LINE_SE0));

endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
    import usb_irq_pkg::*;
#(
    parameter int NUM_EP      = 4,
    parameter int SRC_W       = 8,
    parameter int IDLE_CYCLES = 144000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_EP*SRC_W-1:0] ep_src,
    input  logic [1:0]              bus_state,
    input  logic                    resume_en,
    input  logic                    clk_stopped,
    input  logic                    wr_en,
    input  logic [STAT_W-1:0]       wr_data,
    output logic [STAT_W-1:0]       rd_data,
    output logic                    irq
);

    typedef struct packed {
        logic susp;
        logic resm;
    } flag_state_t;

    flag_state_t st_d, st_q;

    logic [NUM_EP-1:0] ep_flags;
    logic              idle_hit;
    logic              wake_edge;
    line_t             line;

    assign line = line_t'(bus_state);

    ep_summary #(.NUM_EP(NUM_EP), .SRC_W(SRC_W)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (ep_src),
        .flags (ep_flags)
    );

    idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .is_idle (line == LINE_J),
        .expire  (idle_hit)
    );

    line_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .line   (line),
        .j_exit (wake_edge)
    );

    always_comb begin
        st_d = st_q;
        // suspend: timer set has priority over a software clear
        if (idle_hit)
            st_d.susp = 1'b1;
        else if (wr_en && !wr_data[SUSP_POS])
            st_d.susp = 1'b0;
        // resume: no write path, enable low forces clear
        if (!resume_en)
            st_d.resm = 1'b0;
        else if (wake_edge || clk_stopped)
            st_d.resm = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data           = '0;
        rd_data[NUM_EP-1:0] = ep_flags;
        rd_data[SUSP_POS] = st_q.susp;
        rd_data[RESM_POS] = st_q.resm;
    end

    assign irq = (|ep_flags) | st_q.susp | st_q.resm;

endmodule

// File: rtl/usb_irq_status_chk.sv
module usb_irq_status_chk
    import usb_irq_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int SRC_W  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_EP*SRC_W-1:0] ep_src,
    input logic [1:0]              bus_state,
    input logic                    resume_en,
    input logic                    clk_stopped,
    input logic                    wr_en,
    input logic [STAT_W-1:0]       wr_data,
    input logic [STAT_W-1:0]       rd_data,
    input logic                    irq
);

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        // R2
        ep_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (|ep_src[e*SRC_W +: SRC_W]) |=> rd_data[e]);
        // R2
        ep_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(|ep_src[e*SRC_W +: SRC_W]) |=> !rd_data[e]);
    end

    // R4
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[5:4] == 2'b00);

    // R5
    susp_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[SUSP_POS] && bus_state != 2'b01) |=> !rd_data[SUSP_POS]);

    // R6
    susp_wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[SUSP_POS] && bus_state != 2'b01) |=> !rd_data[SUSP_POS]);

    // R7
    resm_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_en && clk_stopped) |=> rd_data[RESM_POS]);

    // R8
    resm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !resume_en |=> !rd_data[RESM_POS]);

    // R9
    irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|{rd_data[RESM_POS], rd_data[SUSP_POS], rd_data[3:0]}));

endmodule

bind usb_irq_status usb_irq_status_chk #(.NUM_EP(NUM_EP), .SRC_W(SRC_W)) u_chk (.*);

// File: tb/sim_usb_irq_status.sv
module sim_usb_irq_status;

    localparam int CLK_PERIOD = 10;
    localparam int IDLE       = 20;
    localparam int WD_LIMIT   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ep_src = '0;
    logic [1:0]  bus_state = 2'b00;
    logic        resume_en = 1'b0;
    logic        clk_stopped = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_irq_status #(.NUM_EP(4), .SRC_W(8), .IDLE_CYCLES(IDLE)) u0 (
        .clk(clk), .rst_n(rst_n), .ep_src(ep_src), .bus_state(bus_state),
        .resume_en(resume_en), .clk_stopped(clk_stopped), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // behavioural reference model
    logic [3:0] m_ep;
    logic       m_sus, m_res, set_now;
    int         m_run;
    logic [1:0] m_prev;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ep = '0; m_sus = 0; m_res = 0; m_run = 0; m_prev = 2'b00;
        end else begin
            set_now = 1'b0;
            for (int i = 0; i < 4; i++) m_ep[i] = |ep_src[i*8 +: 8];
            if (bus_state == 2'b01) begin
                if (m_run < IDLE) begin
                    m_run++;
                    if (m_run == IDLE) set_now = 1'b1;
                end
            end else m_run = 0;
            if (set_now) m_sus = 1'b1;
            else if (wr_en && !wr_data[6]) m_sus = 1'b0;
            if (!resume_en) m_res = 1'b0;
            else if ((m_prev == 2'b01 && (bus_state == 2'b10 || bus_state == 2'b00)) || clk_stopped)
                m_res = 1'b1;
            m_prev = bus_state;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 endpoint flags", {4'h0, rd_data[3:0]}, {4'h0, m_ep});
            check("R4 unused bits", {6'h0, rd_data[5:4]}, 8'h00);
            check("R5/R6 suspend", {7'h0, rd_data[6]}, {7'h0, m_sus});
            check("R7/R8 resume", {7'h0, rd_data[7]}, {7'h0, m_res});
            check("R9 irq", {7'h0, irq}, {7'h0, (|m_ep) | m_sus | m_res});
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > WD_LIMIT && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<%0d", wd, WD_LIMIT);
            finish_run();
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        step(2);
        // R1
        check("R1 reset rd_data", rd_data, 8'h00);
        check("R1 reset irq", {7'h0, irq}, 8'h00);
        rst_n = 1'b1;
        step(1);
        check("R1 after release", rd_data, 8'h00);

        // R2 endpoint summaries
        ep_src = 32'h0000_0001; step(1);
        check("R2 single bit ep0", {4'h0, rd_data[3:0]}, 8'h01);
        ep_src = 32'h8000_0201; step(1);
        check("R2 multi endpoint", {4'h0, rd_data[3:0]}, 8'h0B);
        ep_src = 32'h8000_0210; step(1);
        check("R2 partial change keeps ep0", {4'h0, rd_data[3:0]}, 8'h0B);

        // R3 / R4 writes
        wr_en = 1'b1; wr_data = 8'h00; step(1);
        check("R3 write zero keeps ep flags", {4'h0, rd_data[3:0]}, 8'h0B);
        wr_data = 8'hFF; step(1);
        wr_en = 1'b0;
        check("R4 bits 5:4 stay 0", {6'h0, rd_data[5:4]}, 8'h00);
        check("R6 write one does not set suspend", {7'h0, rd_data[6]}, 8'h00);
        check("R3 write ones keeps resume 0", {7'h0, rd_data[7]}, 8'h00);
        ep_src = '0; step(1);
        check("R2 all clear", rd_data, 8'h00);

        // R5 suspend timing
        bus_state = 2'b01; step(IDLE - 1);
        check("R5 not yet at threshold", {7'h0, rd_data[6]}, 8'h00);
        step(1);
        check("R5 set at threshold", {7'h0, rd_data[6]}, 8'h01);
        check("R9 irq from suspend", {7'h0, irq}, 8'h01);
        wr_en = 1'b1; wr_data = 8'h00; step(1); wr_en = 1'b0;
        check("R6 write zero clears", {7'h0, rd_data[6]}, 8'h00);
        step(5);
        check("R5 once per idle period", {7'h0, rd_data[6]}, 8'h00);
        bus_state = 2'b10; step(1);
        bus_state = 2'b01; step(IDLE - 5);
        bus_state = 2'b00; step(1);
        bus_state = 2'b01; step(IDLE - 1);
        check("R5 restart after SE0", {7'h0, rd_data[6]}, 8'h00);
        step(1);
        check("R5 set after full run", {7'h0, rd_data[6]}, 8'h01);
        bus_state = 2'b10; wr_en = 1'b1; wr_data = 8'h40; step(1);
        check("R6 write one keeps set", {7'h0, rd_data[6]}, 8'h01);
        wr_data = 8'h00; step(1); wr_en = 1'b0;
        check("R6 clear with bus active", {7'h0, rd_data[6]}, 8'h00);

        // R7 / R8 resume
        resume_en = 1'b0; bus_state = 2'b01; step(2);
        bus_state = 2'b10; step(1);
        check("R8 disabled edge ignored", {7'h0, rd_data[7]}, 8'h00);
        resume_en = 1'b1; bus_state = 2'b01; step(2);
        bus_state = 2'b10; step(1);
        check("R7 J to K sets", {7'h0, rd_data[7]}, 8'h01);
        wr_en = 1'b1; wr_data = 8'h00; step(1); wr_en = 1'b0;
        check("R3 write cannot clear resume", {7'h0, rd_data[7]}, 8'h01);
        resume_en = 1'b0; step(1);
        check("R8 enable low clears", {7'h0, rd_data[7]}, 8'h00);
        resume_en = 1'b1; bus_state = 2'b01; step(1);
        bus_state = 2'b00; step(1);
        check("R7 J to SE0 sets", {7'h0, rd_data[7]}, 8'h01);
        resume_en = 1'b0; step(1);
        resume_en = 1'b1; bus_state = 2'b01; step(1);
        bus_state = 2'b11; step(1);
        check("R7 J to invalid ignored", {7'h0, rd_data[7]}, 8'h00);
        bus_state = 2'b01; clk_stopped = 1'b1; step(1);
        check("R7 clock stopped sets", {7'h0, rd_data[7]}, 8'h01);
        check("R9 irq from resume", {7'h0, irq}, 8'h01);
        clk_stopped = 1'b0; resume_en = 1'b0; bus_state = 2'b10; step(1);
        check("R8 cleared again", {7'h0, rd_data[7]}, 8'h00);
        step(3);
        finish_run();
    end

endmodule